// File: doc/BRIEF.md
# Shifter Operand Unit with Carry

This block forms the second source operand of a 32-bit data-processing operation and the carry bit that the shifter produces alongside it. It is purely combinational: the decode stage presents the operand value, an amount field, a 2-bit shift kind, a 2-bit mode and the current carry flag. In the same cycle the unit returns the shaped operand and its carry-out, ready for the ALU and the flag logic.

There are three ways to form the operand. The first shifts a register by a 5-bit constant. The second shifts it by a count held in a second register, of which the low byte is used. The third takes an 8-bit constant, zero-extends it and rotates it right by twice a 4-bit field. Each mode has its own rules for a zero amount and for counts that reach or pass the word width. Those edge rules are the part of the block that most often goes wrong.

Top module: `opnd2_shifter`

## Requirements
- R1: The shift kind code is 0 = logical left, 1 = logical right, 2 = arithmetic right, 3 = rotate right. For a nonzero count n below 32, the carry-out is the last bit moved out of the word: operand bit 32-n for logical left, and operand bit n-1 for the other three kinds.
- R2: In constant-shift mode (mode 0) with a count of zero, logical left leaves the operand as it is and the carry-out equals `i_carry`.
- R3: In constant-shift mode, a count of zero for logical right or arithmetic right acts as a shift by 32. Logical right gives 0. Arithmetic right copies operand bit 31 into every bit. In both cases the carry-out is operand bit 31.
- R4: In constant-shift mode, rotate right with a count of zero is a one-bit rotate through carry. The result is `{i_carry, operand[31:1]}` and the carry-out is operand bit 0.
- R5: In register-shift mode (mode 1) with a count of zero, the result is the operand and the carry-out is `i_carry`, for every kind.
- R6: In register-shift mode, logical left and logical right with a count of 32 or more give 0. At exactly 32 the carry-out is operand bit 0 for left and bit 31 for right. Above 32 the carry-out is 0.
- R7: In register-shift mode, arithmetic right with a count of 32 or more fills every result bit with operand bit 31, and the carry-out is bit 31.
- R8: In register-shift mode, rotate right uses the count modulo 32. A nonzero count whose low five bits are zero leaves the operand unchanged, with carry-out equal to operand bit 31.
- R9: In rotated-constant mode (mode 2), the result is `operand[7:0]` zero-extended and rotated right by 2×`amount[3:0]`. With a nonzero rotate the carry-out is result bit 31. With a rotate of zero the value passes unchanged and the carry-out is `i_carry`.
- R10: Bits outside the field a mode uses have no effect on the result or the carry-out. Constant-shift mode ignores `amount[7:5]`. Rotated-constant mode ignores `amount[7:4]` and `operand[31:8]`. The shift kind is ignored in rotated-constant mode.
- R11: Mode code 3 behaves exactly like mode 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| i_opnd | input | 32 | Register value, or the 8-bit constant in its low byte |
| i_amount | input | 8 | Shift count, or the rotate field in bits 3:0 |
| i_kind | input | 2 | Shift kind code (R1) |
| i_mode | input | 2 | 0 constant shift, 1 register shift, 2 or 3 rotated constant |
| i_carry | input | 1 | Current carry flag |
| o_result | output | 32 | Shaped operand |
| o_carry | output | 1 | Shifter carry-out |

## Verification
In a single evaluation, the one-bit rotate through carry moves the incoming carry into bit 31 of the result while bit 0 of the operand becomes the carry-out. The register-count saturation rules also decide the result and the carry through separate paths, and those paths can disagree at the 32 boundary. The bench provokes these cases by sweeping every kind against every count from 0 to 255 in register mode and every count from 0 to 31 in constant mode. Each case runs with both carry values, on operands whose bit 0 and bit 31 differ. It judges the result and the carry-out together against an arithmetic model built on wide shifts, so a carry taken from the wrong bit or an off-by-one at the boundary both show as miscompares.

// File: rtl/opnd2_pkg.sv
`timescale 1ns/1ps
package opnd2_pkg;
  typedef enum logic [1:0] {
    KIND_LSL = 2'd0,
    KIND_LSR = 2'd1,
    KIND_ASR = 2'd2,
    KIND_ROR = 2'd3
  } kind_e;

  typedef enum logic [1:0] {
    MODE_SHIFT_IMM = 2'd0,
    MODE_SHIFT_REG = 2'd1,
    MODE_ROT_IMM   = 2'd2,
    MODE_ROT_ALT   = 2'd3
  } mode_e;

  // datapath action chosen by the decoder
  typedef enum logic [2:0] {
    OP_PASS, OP_LEFT, OP_RIGHT, OP_ASR, OP_ROR, OP_RRX, OP_ZERO, OP_SIGN
  } op_e;

  // where the carry-out comes from
  typedef enum logic [1:0] {
    CSRC_IN, CSRC_BIT, CSRC_ZERO, CSRC_MSB
  } csrc_e;
endpackage

// File: rtl/opnd2_barrel.sv
`timescale 1ns/1ps
// Log-depth right shifter; wrapped bits come back in rotate mode,
// otherwise the fill bit enters from the top.
module opnd2_barrel #(
  parameter int W = 32
) (
  input  logic [W-1:0]         i_data,
  input  logic [$clog2(W)-1:0] i_amt,
  input  logic                 i_rotate,
  input  logic                 i_fill,
  output logic [W-1:0]         o_data
);
  localparam int LG = $clog2(W);

  logic [LG:0][W-1:0] stage;
  assign stage[0] = i_data;

  for (genvar k = 0; k < LG; k++) begin : g_stage
    localparam int S = 1 << k;
    for (genvar i = 0; i < W; i++) begin : g_bit
      if (i + S < W) begin : g_in
        assign stage[k+1][i] = i_amt[k] ? stage[k][i+S] : stage[k][i];
      end else begin : g_top
        assign stage[k+1][i] = i_amt[k] ? (i_rotate ? stage[k][i+S-W] : i_fill)
                                        : stage[k][i];
      end
    end
  end

  assign o_data = stage[LG];
endmodule

// File: rtl/opnd2_decode.sv
`timescale 1ns/1ps
// Turns mode, kind and amount into a datapath action, an effective
// count and a carry source.
module opnd2_decode
  import opnd2_pkg::*;
#(
  parameter int W     = 32,
  parameter int AMT_W = 8,
  parameter int ROT_W = 4
) (
  input  logic [1:0]           i_mode,
  input  logic [1:0]           i_kind,
  input  logic [AMT_W-1:0]     i_amount,
  output op_e                  o_op,
  output logic [$clog2(W)-1:0] o_n,
  output csrc_e                o_csrc,
  output logic [$clog2(W)-1:0] o_cidx,
  output logic                 o_sel_imm
);
  localparam int LG = $clog2(W);
  localparam logic [LG-1:0] TOP = LG'(W - 1);

  logic [LG-1:0] low_n;
  logic [LG-1:0] rot_n;
  logic          cnt_ge;
  logic          cnt_eq;

  assign low_n  = i_amount[LG-1:0];
  assign rot_n  = LG'({i_amount[ROT_W-1:0], 1'b0});
  assign cnt_ge = (int'(i_amount) >= W);
  assign cnt_eq = (int'(i_amount) == W);

  always_comb begin
    o_op      = OP_PASS;
    o_n       = low_n;
    o_csrc    = CSRC_IN;
    o_cidx    = '0;
    o_sel_imm = 1'b0;
    unique case (mode_e'(i_mode))
      MODE_SHIFT_IMM: begin
        unique case (kind_e'(i_kind))
          KIND_LSL: if (low_n != '0) begin
            o_op = OP_LEFT; o_csrc = CSRC_BIT; o_cidx = LG'(W) - low_n;
          end
          KIND_LSR: begin
            o_csrc = CSRC_BIT;
            if (low_n == '0) begin o_op = OP_ZERO;  o_cidx = TOP; end
            else             begin o_op = OP_RIGHT; o_cidx = low_n - 1'b1; end
          end
          KIND_ASR: begin
            o_csrc = CSRC_BIT;
            if (low_n == '0) begin o_op = OP_SIGN; o_cidx = TOP; end
            else             begin o_op = OP_ASR;  o_cidx = low_n - 1'b1; end
          end
          KIND_ROR: begin
            o_csrc = CSRC_BIT;
            if (low_n == '0) begin o_op = OP_RRX; o_cidx = '0; end
            else             begin o_op = OP_ROR; o_cidx = low_n - 1'b1; end
          end
        endcase
      end
      MODE_SHIFT_REG: begin
        if (i_amount != '0) begin
          unique case (kind_e'(i_kind))
            KIND_LSL: if (cnt_ge) begin
              o_op = OP_ZERO; o_csrc = cnt_eq ? CSRC_BIT : CSRC_ZERO; o_cidx = '0;
            end else begin
              o_op = OP_LEFT; o_csrc = CSRC_BIT; o_cidx = LG'(W) - low_n;
            end
            KIND_LSR: if (cnt_ge) begin
              o_op = OP_ZERO; o_csrc = cnt_eq ? CSRC_BIT : CSRC_ZERO; o_cidx = TOP;
            end else begin
              o_op = OP_RIGHT; o_csrc = CSRC_BIT; o_cidx = low_n - 1'b1;
            end
            KIND_ASR: begin
              o_csrc = CSRC_BIT;
              if (cnt_ge) begin o_op = OP_SIGN; o_cidx = TOP; end
              else        begin o_op = OP_ASR;  o_cidx = low_n - 1'b1; end
            end
            KIND_ROR: begin
              o_csrc = CSRC_BIT;
              if (low_n == '0) begin o_op = OP_PASS; o_cidx = TOP; end
              else             begin o_op = OP_ROR;  o_cidx = low_n - 1'b1; end
            end
          endcase
        end
      end
      default: begin
        o_sel_imm = 1'b1;
        o_n       = rot_n;
        if (rot_n != '0) begin
          o_op = OP_ROR; o_csrc = CSRC_MSB;
        end
      end
    endcase
  end
endmodule

// File: rtl/opnd2_shifter.sv
`timescale 1ns/1ps
module opnd2_shifter
  import opnd2_pkg::*;
#(
  parameter int W     = 32,
  parameter int AMT_W = 8,
  parameter int IMM_W = 8,
  parameter int ROT_W = 4
) (
  input  logic [W-1:0]     i_opnd,
  input  logic [AMT_W-1:0] i_amount,
  input  logic [1:0]       i_kind,
  input  logic [1:0]       i_mode,
  input  logic             i_carry,
  output logic [W-1:0]     o_result,
  output logic             o_carry
);
  localparam int LG = $clog2(W);

  op_e           op;
  csrc_e         csrc;
  logic [LG-1:0] n;
  logic [LG-1:0] cidx;
  logic          sel_imm;

  opnd2_decode #(.W(W), .AMT_W(AMT_W), .ROT_W(ROT_W)) u_decode (
    .i_mode    (i_mode),
    .i_kind    (i_kind),
    .i_amount  (i_amount),
    .o_op      (op),
    .o_n       (n),
    .o_csrc    (csrc),
    .o_cidx    (cidx),
    .o_sel_imm (sel_imm)
  );

  logic [W-1:0] src;
  logic [W-1:0] src_rev;
  logic [W-1:0] bar_in;
  logic [W-1:0] bar_out;
  logic [W-1:0] bar_rev;

  assign src = sel_imm ? W'(i_opnd[IMM_W-1:0]) : i_opnd;

  // left shifts reuse the right shifter on bit-reversed data
  for (genvar i = 0; i < W; i++) begin : g_rev
    assign src_rev[i] = src[W-1-i];
    assign bar_rev[i] = bar_out[W-1-i];
  end

  assign bar_in = (op == OP_LEFT) ? src_rev : src;

  opnd2_barrel #(.W(W)) u_barrel (
    .i_data   (bar_in),
    .i_amt    (n),
    .i_rotate (op == OP_ROR),
    .i_fill   ((op == OP_ASR) & src[W-1]),
    .o_data   (bar_out)
  );

  always_comb begin
    unique case (op)
      OP_PASS:  o_result = src;
      OP_LEFT:  o_result = bar_rev;
      OP_RRX:   o_result = {i_carry, src[W-1:1]};
      OP_ZERO:  o_result = '0;
      OP_SIGN:  o_result = {W{src[W-1]}};
      default:  o_result = bar_out;
    endcase
  end

  always_comb begin
    unique case (csrc)
      CSRC_IN:   o_carry = i_carry;
      CSRC_BIT:  o_carry = src[cidx];
      CSRC_ZERO: o_carry = 1'b0;
      default:   o_carry = o_result[W-1];
    endcase
  end

  // port-level checks of the edge rules
  always_comb begin
    if (i_mode == 2'd1 && i_amount == '0) begin
      a_r5_zero_count_passes: assert (o_result == i_opnd && o_carry == i_carry)
        else $error("R5 register count zero altered operand or carry");
    end
    if (i_mode == 2'd1 && i_kind[1] == 1'b0 && int'(i_amount) > W) begin
      a_r6_beyond_width_clears: assert (o_result == '0 && o_carry == 1'b0)
        else $error("R6 logical shift beyond width not cleared");
    end
    if (i_mode == 2'd1 && i_kind == 2'd2 && int'(i_amount) >= W) begin
      a_r7_sign_flood: assert (o_result == {W{i_opnd[W-1]}} && o_carry == i_opnd[W-1])
        else $error("R7 arithmetic saturation wrong");
    end
    if (i_mode == 2'd0 && i_kind == 2'd3 && i_amount[LG-1:0] == '0) begin
      a_r4_rrx_through_carry: assert (o_result == {i_carry, i_opnd[W-1:1]} && o_carry == i_opnd[0])
        else $error("R4 rotate through carry wrong");
    end
    if (i_mode[1] && i_amount[ROT_W-1:0] != '0) begin
      a_r9_const_carry_msb: assert (o_carry == o_result[W-1] && o_result != '0 || i_opnd[IMM_W-1:0] == '0)
        else $error("R9 rotated constant carry or value wrong");
    end
  end
endmodule

// File: tb/tb_opnd2_shifter.sv
`timescale 1ns/1ps
module tb_opnd2_shifter;
  logic        clk = 1'b0;
  logic [31:0] opnd;
  logic [7:0]  amount;
  logic [1:0]  kind;
  logic [1:0]  mode;
  logic        cin;
  logic [31:0] result;
  logic        cout;

  int unsigned n_vec  = 0;
  int unsigned n_miss = 0;
  bit          done   = 1'b0;

  always #2.5 clk = ~clk;

  opnd2_shifter dut (
    .i_opnd   (opnd),
    .i_amount (amount),
    .i_kind   (kind),
    .i_mode   (mode),
    .i_carry  (cin),
    .o_result (result),
    .o_carry  (cout)
  );

  // arithmetic model: returns {carry, result}
  function automatic logic [32:0] model(input logic [1:0] md, input logic [1:0] kd,
                                        input logic [7:0] am, input logic [31:0] x,
                                        input logic ci);
    logic [287:0] t;
    logic [63:0]  d;
    logic [31:0]  v;
    int           e;
    int           sh;
    if (md == 2'd0) begin
      sh = int'(am[4:0]);
      if (kd == 2'd0) begin
        if (sh == 0) return {ci, x};
        t = {256'b0, x} << sh;
        return {t[32], t[31:0]};
      end else if (kd == 2'd3) begin
        if (sh == 0) return {x[0], ci, x[31:1]};
        d = {x, x} >> sh;
        return {d[31], d[31:0]};
      end else begin
        e = (sh == 0) ? 32 : sh;
        if (kd == 2'd1) t = {x, 256'b0} >> e;
        else            t = $signed({x, 256'b0}) >>> e;
        return {t[255], t[287:256]};
      end
    end else if (md == 2'd1) begin
      if (am == 8'd0) return {ci, x};
      unique case (kd)
        2'd0: begin t = {256'b0, x} << am; return {t[32], t[31:0]}; end
        2'd1: begin t = {x, 256'b0} >> am; return {t[255], t[287:256]}; end
        2'd2: begin t = $signed({x, 256'b0}) >>> am; return {t[255], t[287:256]}; end
        default: begin
          sh = int'(am) % 32;
          if (sh == 0) return {x[31], x};
          d = {x, x} >> sh;
          return {d[31], d[31:0]};
        end
      endcase
    end else begin
      v  = {24'b0, x[7:0]};
      sh = 2 * int'(am[3:0]);
      if (sh == 0) return {ci, v};
      d = {v, v} >> sh;
      return {d[31], d[31:0]};
    end
  endfunction

  function automatic string tag(input logic [1:0] md, input logic [1:0] kd,
                                input logic [7:0] am);
    if (md == 2'd3) return "R11";
    if (md == 2'd2) return (am[7:4] != 4'd0 || kd != 2'd0) ? "R10" : "R9";
    if (md == 2'd0) begin
      if (am[7:5] != 3'd0) return "R10";
      if (am[4:0] == 5'd0) return (kd == 2'd0) ? "R2" : (kd == 2'd3) ? "R4" : "R3";
      return "R1";
    end
    if (am == 8'd0) return "R5";
    if (kd == 2'd3) return "R8";
    if (am >= 8'd32) return (kd == 2'd2) ? "R7" : "R6";
    return "R1";
  endfunction

  task automatic apply(input logic [1:0] md, input logic [1:0] kd,
                       input logic [7:0] am, input logic [31:0] x, input logic ci);
    logic [32:0] exp;
    @(posedge clk);
    #1;
    mode = md; kind = kd; amount = am; opnd = x; cin = ci;
    @(negedge clk);
    exp = model(md, kd, am, x, ci);
    n_vec++;
    if ({cout, result} !== exp) begin
      n_miss++;
      $display("FAIL %s mode=%0d kind=%0d amt=%0d opnd=%h cin=%b: got c=%b r=%h, want c=%b r=%h",
               tag(md, kd, am), md, kd, am, x, ci, cout, result, exp[32], exp[31:0]);
    end
  endtask

  localparam int NPAT = 8;
  logic [31:0] pats [NPAT] = '{32'h0000_0000, 32'hFFFF_FFFF, 32'h8000_0001,
                               32'h7FFF_FFFE, 32'h8000_0000, 32'h0000_0001,
                               32'hA5C3_0F96, 32'h1234_56F7};

  initial begin
    mode = 2'd0; kind = 2'd0; amount = 8'd0; opnd = 32'd0; cin = 1'b0;
    // R1..R4, R10: constant counts 0..31, with and without ignored high bits
    for (int p = 0; p < NPAT; p++)
      for (int k = 0; k < 4; k++)
        for (int a = 0; a < 32; a++)
          for (int c = 0; c < 2; c++) begin
            apply(2'd0, 2'(k), 8'(a), pats[p], 1'(c));
            apply(2'd0, 2'(k), 8'(a) | 8'hE0, pats[p], 1'(c));
          end
    // R5..R8: every register count 0..255
    for (int p = 0; p < NPAT; p++)
      for (int k = 0; k < 4; k++)
        for (int a = 0; a < 256; a++)
          for (int c = 0; c < 2; c++)
            apply(2'd1, 2'(k), 8'(a), pats[p], 1'(c));
    // R9, R10, R11: rotated constants, every rotate field
    for (int p = 0; p < NPAT; p++)
      for (int r = 0; r < 16; r++)
        for (int c = 0; c < 2; c++) begin
          apply(2'd2, 2'd0, 8'(r), pats[p], 1'(c));
          apply(2'd2, 2'(r), 8'(r) | 8'hF0, pats[p], 1'(c));
          apply(2'd3, 2'd1, 8'(r), pats[p], 1'(c));
        end
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
    $finish;
  end

  initial begin
    #600us;
    if (!done) begin
      n_miss++;
      $display("FAIL watchdog: got no completion, want completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
      $finish;
    end
  end
endmodule